// File: doc/BRIEF.md
# Toggle Bit Polling Controller

This block sits on the host side of a flash memory and decides whether a program or erase operation that has already been issued has finished successfully. Once started, it repeatedly reads a status byte from a caller-supplied address over a simple request/acknowledge read port. The embedded operation counts as still running while bit 6 of the status byte keeps changing between reads. Bit 5 is a timeout flag. Reads are always done in pairs, and the result is decided by comparing bit 6 across each pair.

If a pair shows toggling and bit 5 is set, the controller does not fail straight away. Toggling may stop in the same moment that the timeout flag rises, so one more pair is read. Only if that final pair still toggles is the result a failure. When the first status read goes to a different bank than the last erased sector, an optional start delay, chosen per run by an input flag, holds off the first read. A parameterised limit on the number of read pairs ends a poll that never settles.

The caller pulses `start` together with the address and the bank flag. It then waits for the one-cycle `done` pulse and reads `pass` in that same cycle.

Top module: `status_toggle_poller`

## Requirements
- R1: When the two status reads of a pair have equal bit 6, the run ends with pass=1. `done` rises in the cycle after the clock edge that took the second acknowledge.
- R2: When bit 6 differs within a pair and bit 5 of the second read is 0, the controller starts another pair of reads.
- R3: When bit 6 differs within a pair and bit 5 of the second read is 1, exactly one more pair is read. The result is pass if bit 6 is equal in that pair and fail if it differs. No further reads follow.
- R4: Bit 5 has no effect when bit 6 is equal within a pair. The result is then pass.
- R5: With `crossBank`=1, the first read request rises BANK_DELAY_CYC+1 cycles after the edge that accepted `start`. With `crossBank`=0, it rises in the cycle right after that edge.
- R6: With POLL_LIMIT nonzero, a run whose first POLL_LIMIT pairs all toggle with bit 5 at 0 ends with pass=0 after exactly 2*POLL_LIMIT reads.
- R7: A `start` pulse while `busy` is high is ignored: it changes neither the address nor the run. `rdReq` is never high while the block is idle.
- R8: `done` is high for exactly one cycle per run, `pass` is meaningful only in that cycle, and the block is idle (`busy`=0) in the next cycle.
- R9: `rdAddr` carries the address that was present with the accepted `start` and stays stable for the whole run.
- R10: `rdReq` stays high until `rdAck`. The status byte is taken from `rdData` in the acknowledge cycle, whatever the response latency.
- R11: After reset, `busy`, `done`, `pass` and `rdReq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a poll (accepted only when idle) |
| crossBank | input | 1 | Insert the start delay before the first read |
| startAddr | input | ADDR_W | Address to poll, captured at start |
| busy | output | 1 | A poll is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid while done is high |
| rdReq | output | 1 | Read request, held until acknowledged |
| rdAddr | output | ADDR_W | Read address |
| rdAck | input | 1 | Read acknowledge; rdData valid in this cycle |
| rdData | input | 8 | Status byte returned by the read |

## Verification
The scripted status sequences cover several cases that the decision logic must tell apart:
- an immediately stable pair (R1);
- toggling that stops after a few pairs (R2);
- a raised timeout flag followed by either a stable or a still-toggling confirmation pair (R3);
- a timeout flag on an already stable pair, which checks that bit 5 is ignored there (R4);
- an endlessly alternating byte, which can only end through the pair limit (R6).

The number of reads issued for each of these sequences shows whether an extra pair was added or skipped. Response latencies of zero and several cycles separate true handshake behaviour from fixed timing. The delay to the first request, with and without the bank flag, shows whether the start delay is applied.

// File: rtl/poll_pkg.sv
package poll_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAddr;   // capture address, clear counters
    logic runDelay;   // advance start-delay counter
    logic capFirst;   // capture bit 6 of first read of a pair
    logic incPair;    // count a completed toggling pair
  } strobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic toggled;    // bit 6 of current read differs from stored one
    logic timeoutBit; // bit 5 of current read
    logic limitHit;   // current pair is the last one allowed
    logic delayDone;  // start delay elapsed
  } stat_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_RD1  = 3'd2,
    ST_RD2  = 3'd3,
    ST_FIN  = 3'd4
  } pstate_t;

endpackage

// File: rtl/poll_dp.sv
module poll_dp
  import poll_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int BANK_DELAY_CYC = 20000,
  parameter int POLL_LIMIT     = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           sb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [1:0]        rdBits,    // {bit6, bit5} of the returned byte
  output stat_t             st,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam int DLY_W  = $clog2(BANK_DELAY_CYC + 1);
  localparam int POLL_W = (POLL_LIMIT < 2) ? 1 : $clog2(POLL_LIMIT);

  logic [ADDR_W-1:0] addrReg;
  logic [DLY_W-1:0]  delayCnt;
  logic              prevBit6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg  <= '0;
      delayCnt <= '0;
      prevBit6 <= 1'b0;
    end else begin
      if (sb.loadAddr) begin
        addrReg  <= startAddr;
        delayCnt <= '0;
      end else if (sb.runDelay) begin
        delayCnt <= delayCnt + 1'b1;
      end
      if (sb.capFirst) prevBit6 <= rdBits[1];
    end
  end

  assign rdAddr        = addrReg;
  assign st.toggled    = rdBits[1] ^ prevBit6;
  assign st.timeoutBit = rdBits[0];
  assign st.delayDone  = (delayCnt == DLY_W'(BANK_DELAY_CYC - 1));

  generate
    if (POLL_LIMIT == 0) begin : g_noLimit
      assign st.limitHit = 1'b0;
    end else begin : g_limit
      logic [POLL_W-1:0] pairCnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pairCnt <= '0;
        else if (sb.loadAddr)   pairCnt <= '0;
        else if (sb.incPair)    pairCnt <= pairCnt + 1'b1;
      end
      assign st.limitHit = (pairCnt == POLL_W'(POLL_LIMIT - 1));
    end
  endgenerate

endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    crossBank,
  input  logic    rdAck,
  input  stat_t   st,
  output strobe_t sb,
  output logic    busy,
  output logic    done,
  output logic    pass,
  output logic    rdReq
);

  pstate_t state, stateNxt;
  logic    recheck, recheckNxt;
  logic    result, resultNxt;

  always_comb begin
    stateNxt   = state;
    recheckNxt = recheck;
    resultNxt  = result;
    sb         = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        sb.loadAddr = 1'b1;
        recheckNxt  = 1'b0;
        stateNxt    = crossBank ? ST_WAIT : ST_RD1;
      end
      ST_WAIT: begin
        sb.runDelay = 1'b1;
        if (st.delayDone) stateNxt = ST_RD1;
      end
      ST_RD1: if (rdAck) begin
        sb.capFirst = 1'b1;
        stateNxt    = ST_RD2;
      end
      ST_RD2: if (rdAck) begin
        if (!st.toggled) begin
          resultNxt = 1'b1;
          stateNxt  = ST_FIN;
        end else if (recheck || st.limitHit) begin
          resultNxt = 1'b0;
          stateNxt  = ST_FIN;
        end else begin
          sb.incPair = 1'b1;
          if (st.timeoutBit) recheckNxt = 1'b1;
          stateNxt = ST_RD1;
        end
      end
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      recheck <= 1'b0;
      result  <= 1'b0;
    end else begin
      state   <= stateNxt;
      recheck <= recheckNxt;
      result  <= resultNxt;
    end
  end

  assign busy  = (state != ST_IDLE);
  assign rdReq = (state == ST_RD1) || (state == ST_RD2);
  assign done  = (state == ST_FIN);
  assign pass  = done & result;

endmodule

// File: rtl/status_toggle_poller.sv
module status_toggle_poller
  import poll_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int BANK_DELAY_CYC = 20000,
  parameter int POLL_LIMIT     = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              crossBank,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [7:0]        rdData
);

  strobe_t sb;
  stat_t   st;
  logic    unusedBits;

  assign unusedBits = ^{rdData[7], rdData[4:0]};

  poll_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .crossBank (crossBank),
    .rdAck     (rdAck),
    .st        (st),
    .sb        (sb),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .rdReq     (rdReq)
  );

  poll_dp #(
    .ADDR_W         (ADDR_W),
    .BANK_DELAY_CYC (BANK_DELAY_CYC),
    .POLL_LIMIT     (POLL_LIMIT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sb        (sb),
    .startAddr (startAddr),
    .rdBits    (rdData[6:5]),
    .st        (st),
    .rdAddr    (rdAddr)
  );

endmodule

// File: rtl/status_toggle_poller_chk.sv
module status_toggle_poller_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              rdReq,
  input logic              rdAck,
  input logic [ADDR_W-1:0] rdAddr
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && !rdAck) |=> rdReq);                                   // R10

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rdReq);                                              // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                // R8

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);                                                // R8

  AST_END_VIA_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));                                   // R8

  AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);                                                 // R8

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rdAddr));                     // R9

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);                             // R7

endmodule

bind status_toggle_poller status_toggle_poller_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .pass   (pass),
  .rdReq  (rdReq),
  .rdAck  (rdAck),
  .rdAddr (rdAddr)
);

// File: tb/sim_status_toggle_poller.sv
module sim_status_toggle_poller;

  localparam int AW       = 16;
  localparam int TB_DELAY = 12;
  localparam int TB_LIMIT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          crossBank = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          busy, done, pass, rdReq;
  logic [AW-1:0] rdAddr;
  logic          rdAck = 1'b0;
  logic [7:0]    rdData = 8'h00;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // responder state
  logic [7:0]    script [0:15];
  int            scriptLen = 0;
  logic          altMode = 1'b0;
  int            lat = 0;
  int            idx = 0;
  int            reads = 0;
  int            waitCnt = 0;
  logic [AW-1:0] expAddr = '0;
  int            addrErr = 0;

  always #5 clk = ~clk;

  status_toggle_poller #(
    .ADDR_W(AW), .BANK_DELAY_CYC(TB_DELAY), .POLL_LIMIT(TB_LIMIT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .crossBank(crossBank),
    .startAddr(startAddr), .busy(busy), .done(done), .pass(pass),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      summary();
    end
  end

  // read responder: acks after lat cycles, counts reads, checks address
  initial forever begin
    @(negedge clk);
    if (rdAck) begin
      rdAck = 1'b0;
      waitCnt = 0;
    end else if (rdReq) begin
      if (waitCnt >= lat) begin
        if (altMode)            rdData = idx[0] ? 8'h40 : 8'h00;
        else if (idx < scriptLen) rdData = script[idx];
        else                    rdData = script[scriptLen-1];
        if (rdAddr != expAddr) addrErr++;
        rdAck = 1'b1;
        idx++;
        reads++;
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic load(input logic [7:0] b0, b1, b2, b3, input int n);
    script[0] = b0; script[1] = b1; script[2] = b2; script[3] = b3;
    scriptLen = n;
    idx = 0;
    reads = 0;
    addrErr = 0;
  endtask

  // returns cycles from start acceptance to first rdReq
  task automatic runStart(input logic cb, input logic [AW-1:0] a, output int firstReq);
    @(negedge clk);
    start = 1'b1; crossBank = cb; startAddr = a; expAddr = a;
    @(negedge clk);
    start = 1'b0; crossBank = 1'b0; startAddr = '0;
    firstReq = 1;
    while (!rdReq && firstReq < 1000) begin
      @(negedge clk);
      firstReq++;
    end
  endtask

  task automatic waitDone(input string req, input int expPass, input int expReads);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check({req, " done seen"}, done, 1);
    check({req, " pass"}, pass, expPass);
    check({req, " read count"}, reads, expReads);
    check({req, " R9 address"}, addrErr, 0);
    @(negedge clk);
    check({req, " R8 done one cycle"}, done, 0);
    check({req, " R8 idle after done"}, busy, 0);
  endtask

  task automatic tReset();
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 pass", pass, 0);
    check("R11 rdReq", rdReq, 0);
  endtask

  task automatic tStable();
    int fr;
    lat = 0; altMode = 1'b0;
    load(8'h40, 8'h40, 8'h40, 8'h40, 2);
    runStart(1'b0, 16'h1234, fr);
    check("R5 no delay first request", fr, 1);
    waitDone("R1", 1, 2);
  endtask

  task automatic tToggleStops();
    int fr;
    lat = 3; altMode = 1'b0;
    load(8'h00, 8'h40, 8'h40, 8'h40, 4);
    runStart(1'b0, 16'h00A0, fr);
    waitDone("R2 R10", 1, 4);
  endtask

  task automatic tTimeoutFail();
    int fr;
    lat = 1; altMode = 1'b0;
    load(8'h00, 8'h60, 8'h20, 8'h60, 4);
    runStart(1'b0, 16'h0F0F, fr);
    waitDone("R3 fail", 0, 4);
  endtask

  task automatic tTimeoutLate();
    int fr;
    lat = 0; altMode = 1'b0;
    load(8'h00, 8'h60, 8'h60, 8'h60, 4);
    runStart(1'b0, 16'h0101, fr);
    waitDone("R3 pass", 1, 4);
  endtask

  task automatic tBit5NoToggle();
    int fr;
    lat = 2; altMode = 1'b0;
    load(8'h60, 8'h60, 8'h60, 8'h60, 2);
    runStart(1'b0, 16'h0202, fr);
    waitDone("R4", 1, 2);
  endtask

  task automatic tCrossBank();
    int fr;
    lat = 0; altMode = 1'b0;
    load(8'h20, 8'h20, 8'h20, 8'h20, 2);
    runStart(1'b1, 16'hBEEF, fr);
    check("R5 delayed first request", fr, TB_DELAY + 1);
    waitDone("R5", 1, 2);
  endtask

  task automatic tLimit();
    int fr;
    lat = 0; altMode = 1'b1;
    load(8'h00, 8'h00, 8'h00, 8'h00, 1);
    runStart(1'b0, 16'h7777, fr);
    waitDone("R6", 0, 2 * TB_LIMIT);
    altMode = 1'b0;
  endtask

  task automatic tStartWhileBusy();
    int fr;
    int reqSeen = 0;
    lat = 3; altMode = 1'b0;
    load(8'h00, 8'h40, 8'h40, 8'h40, 4);
    runStart(1'b0, 16'h5555, fr);
    repeat (3) @(negedge clk);
    start = 1'b1; startAddr = 16'hAAAA;
    @(negedge clk);
    start = 1'b0; startAddr = '0;
    waitDone("R7", 1, 4);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rdReq || busy) reqSeen++;
    end
    check("R7 no second run", reqSeen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1'b1;
    @(negedge clk);
    tStable();
    tToggleStops();
    tTimeoutFail();
    tTimeoutLate();
    tBit5NoToggle();
    tCrossBank();
    tLimit();
    tStartWhileBusy();
    summary();
  end

endmodule